// File: doc/BRIEF.md
# Dual Interval Timer with Interrupt Control

This peripheral holds two 16-bit down-counters, timer A and timer B, behind a small synchronous register bus. Each timer has a reload latch written one byte at a time and a control register. The control register starts or stops the timer, chooses between free-running and single-shot operation, and can force the latch into the counter. The counters step once for each clock cycle in which the phase-2 count-enable input is high.

When a timer underflows, it reloads from its latch and raises an event flag. A shared interrupt register holds an enable mask. Writes to it set or clear mask bits, and reads return the flags and clear them. While any flagged event is enabled, the active-low interrupt output is held low. It stays low until software reads the interrupt register, so a consumer that detects the falling edge sees exactly one edge per acknowledge.

Top module: `ivt_timer_pair`

## Requirements
- R1: After reset the interrupt output is high, and reads of the interrupt register (offset 0xD) and of both control registers (0xE for A, 0xF for B) return 0x00.
- R2: In free-running mode (control bit 0 = 1, bit 3 = 0), with the count enable held high, successive underflows of a timer are exactly latch+1 cycles apart. The timer keeps running after each reload.
- R3: In single-shot mode (control bits 0 and 3 = 1), the first underflow comes latch+1 cycles after the start write, with latch 0 giving 1 cycle. The timer then stops, raises no further event, and its control register reads back with bit 0 clear.
- R4: Timer A's latch is written at offsets 0x4 (low byte) and 0x5 (high byte), and timer B's at 0x6 and 0x7. Reads of these offsets return the current counter bytes. A high-byte write loads the whole latch into the counter only while that timer is stopped.
- R5: Writing control bit 4 as 1 copies the latch into the counter at once, even while the timer runs. Bit 4 always reads back as 0.
- R6: A write to 0xD with bit 7 = 1 sets the mask bits that are written as 1 (bit 0 for A, bit 1 for B). With bit 7 = 0 it clears them. Mask bits written as 0 keep their value, and a masked-off event never pulls the interrupt output low.
- R7: A read of 0xD returns timer A's flag in bit 0, timer B's flag in bit 1, and in bit 7 whether any flagged event is enabled. The read clears the flags and releases the interrupt output.
- R8: The interrupt output goes low in the cycle after an enabled event is flagged. It stays low, with no second falling edge, until the interrupt register is read.
- R9: An underflow in the same cycle as a read of 0xD sets its flag after the clear, so the event survives and the output stays low.
- R10: While the count enable is low, the counters hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Phase-2 count enable, one count step per high cycle |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read; reading 0xD acknowledges |
| rdata | output | 8 | Read data, valid in the cycle of the strobe |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
On every cycle the embedded properties check the following:
- a running counter steps down by exactly one per enabled cycle and freezes when the enable is low;
- an underflow reloads the latch and ends single-shot operation;
- a flag can rise only after an underflow of its own timer;
- the mask changes only on a write;
- a held interrupt stays low until a read, and a clean acknowledge releases it.

The exact spacing of latch+1 cycles between falling edges, the byte values seen on reads, and the single-shot one-cycle case with latch 0 can only be shown by the directed scenarios. So can the loading rules for high-byte and forced loads and the collision of an underflow with an acknowledge.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
   localparam int BYTE_W     = 8;
   localparam int REG_ADDR_W = 4;

   localparam logic [REG_ADDR_W-1:0] ADR_TMR_BASE = 4'h4;
   localparam logic [REG_ADDR_W-1:0] ADR_ICR      = 4'hD;
   localparam logic [REG_ADDR_W-1:0] ADR_CR_BASE  = 4'hE;

   localparam int CR_START   = 0;
   localparam int CR_ONESHOT = 3;
   localparam int CR_FLOAD   = 4;
   localparam int ICR_SETSEL = 7;

   typedef struct packed {
      logic oneshot;
      logic start;
   } tmr_mode_t;
endpackage

// File: rtl/ivt_counter.sv
module ivt_counter
   import ivt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_en,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic              wr_cr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [CNT_W-1:0]  count,
   output tmr_mode_t         mode,
   output logic              uf
);
   localparam int HI_W = CNT_W - BYTE_W;

   initial begin
      if (CNT_W != 2*BYTE_W) $error("ivt_counter: CNT_W must be two bytes");
   end

   logic [CNT_W-1:0] latch_q;
   logic             fload;

   assign uf    = mode.start & cnt_en & (count == '0);
   assign fload = wr_cr & wdata[CR_FLOAD];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         latch_q <= '1;
      end else begin
         if (wr_lo) latch_q[BYTE_W-1:0]     <= wdata;
         if (wr_hi) latch_q[CNT_W-1:BYTE_W] <= wdata[HI_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '1;
      end else if (fload) begin
         count <= latch_q;
      end else if (uf) begin
         count <= latch_q;
      end else if (wr_hi && !mode.start) begin
         count <= {wdata[HI_W-1:0], latch_q[BYTE_W-1:0]};
      end else if (mode.start && cnt_en) begin
         count <= count - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode <= '0;
      end else if (wr_cr) begin
         mode.start   <= wdata[CR_START];
         mode.oneshot <= wdata[CR_ONESHOT];
      end else if (uf && mode.oneshot) begin
         mode.start <= 1'b0;
      end
   end

   a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
      (mode.start && cnt_en && count != '0 && !wr_cr && !wr_hi)
      |=> (count == $past(count) - 1'b1));

   a_r2_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (uf && !wr_lo && !wr_hi) |=> (count == $past(latch_q)));

   a_r3_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (uf && mode.oneshot && !wr_cr) |=> !mode.start);

   a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en && !wr_cr && !wr_hi) |=> $stable(count));
endmodule

// File: rtl/ivt_irq_ctrl.sv
module ivt_irq_ctrl
   import ivt_pkg::*;
#(
   parameter int NSRC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   uf,
   input  logic              icr_wr,
   input  logic              icr_rd,
   input  logic              set_sel,
   input  logic [NSRC-1:0]   sel,
   output logic [NSRC-1:0]   flags,
   output logic [NSRC-1:0]   mask,
   output logic [BYTE_W-1:0] status,
   output logic              irq_n
);
   localparam int PAD_W = BYTE_W - 1 - NSRC;

   initial begin
      if (NSRC < 1 || NSRC > BYTE_W-1) $error("ivt_irq_ctrl: NSRC out of range");
   end

   logic active;
   assign active = |(flags & mask);
   assign irq_n  = ~active;

   generate
      if (PAD_W > 0) begin : g_pad
         assign status = {active, {PAD_W{1'b0}}, flags};
      end else begin : g_nopad
         assign status = {active, flags};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) flags <= '0;
      else        flags <= (icr_rd ? '0 : flags) | uf;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask <= '0;
      end else if (icr_wr) begin
         if (set_sel) mask <= mask | sel;
         else         mask <= mask & ~sel;
      end
   end

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_chk
         a_r7_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[i]) |-> $past(uf[i]));
      end
   endgenerate

   a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !icr_wr |=> $stable(mask));

   a_r8_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_n && !icr_rd && !icr_wr) |=> !irq_n);
endmodule

// File: rtl/ivt_timer_pair.sv
module ivt_timer_pair
   import ivt_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int NUM_TMR = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cnt_en,
   input  logic [REG_ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0]     wdata,
   input  logic                  wr_en,
   input  logic                  rd_en,
   output logic [BYTE_W-1:0]     rdata,
   output logic                  irq_n
);
   localparam int HI_W = CNT_W - BYTE_W;

   initial begin
      if (NUM_TMR != 2)       $error("ivt_timer_pair: register map holds two timers");
      if (CNT_W != 2*BYTE_W)  $error("ivt_timer_pair: CNT_W must be two bytes");
   end

   logic [CNT_W-1:0]   cnt_q [NUM_TMR];
   tmr_mode_t          mode_q[NUM_TMR];
   logic [NUM_TMR-1:0] uf;
   logic [NUM_TMR-1:0] flags, mask;
   logic [BYTE_W-1:0]  status;
   logic               icr_wr, icr_rd;

   assign icr_wr = wr_en && (addr == ADR_ICR);
   assign icr_rd = rd_en && (addr == ADR_ICR);

   generate
      for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
         localparam logic [REG_ADDR_W-1:0] A_LO = ADR_TMR_BASE + REG_ADDR_W'(2*i);
         localparam logic [REG_ADDR_W-1:0] A_HI = ADR_TMR_BASE + REG_ADDR_W'(2*i + 1);
         localparam logic [REG_ADDR_W-1:0] A_CR = ADR_CR_BASE + REG_ADDR_W'(i);

         ivt_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .cnt_en(cnt_en),
            .wr_lo (wr_en && addr == A_LO),
            .wr_hi (wr_en && addr == A_HI),
            .wr_cr (wr_en && addr == A_CR),
            .wdata (wdata),
            .count (cnt_q[i]),
            .mode  (mode_q[i]),
            .uf    (uf[i])
         );
      end
   endgenerate

   ivt_irq_ctrl #(.NSRC(NUM_TMR)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .uf     (uf),
      .icr_wr (icr_wr),
      .icr_rd (icr_rd),
      .set_sel(wdata[ICR_SETSEL]),
      .sel    (wdata[NUM_TMR-1:0]),
      .flags  (flags),
      .mask   (mask),
      .status (status),
      .irq_n  (irq_n)
   );

   always_comb begin
      rdata = '0;
      case (addr)
         4'h4:    rdata = cnt_q[0][BYTE_W-1:0];
         4'h5:    rdata = BYTE_W'(cnt_q[0][CNT_W-1:BYTE_W]);
         4'h6:    rdata = cnt_q[1][BYTE_W-1:0];
         4'h7:    rdata = BYTE_W'(cnt_q[1][CNT_W-1:BYTE_W]);
         ADR_ICR: rdata = status;
         4'hE: begin
            rdata[CR_START]   = mode_q[0].start;
            rdata[CR_ONESHOT] = mode_q[0].oneshot;
         end
         4'hF: begin
            rdata[CR_START]   = mode_q[1].start;
            rdata[CR_ONESHOT] = mode_q[1].oneshot;
         end
         default: rdata = '0;
      endcase
   end

   a_r7_ack_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (icr_rd && uf == '0 && !icr_wr) |=> irq_n);

   a_r9_collision_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (icr_rd && |(uf & mask) && !icr_wr) |=> !irq_n);
endmodule

// File: tb/tb_ivt_timer_pair.sv
module tb_ivt_timer_pair;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cnt_en = 1'b1;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] rdata;
   logic       irq_n;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int fall_n = 0;
   int last_fall = 0;
   logic irq_prev = 1'b1;
   bit done = 0;

   ivt_timer_pair dut (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .addr(addr), .wdata(wdata),
      .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .irq_n(irq_n)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (irq_prev && !irq_n) begin
         fall_n    <= fall_n + 1;
         last_fall <= cyc;
      end
      irq_prev <= irq_n;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic wait_fall(input int n0);
      while (fall_n == n0) @(negedge clk);
   endtask

   task automatic flush();
      logic [7:0] d;
      wr(4'hE, 8'h00); wr(4'hF, 8'h00);
      rd(4'hD, d); rd(4'hD, d);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check(irq_n === 1'b1, "R1 irq_n after reset", irq_n, 1);
      rd(4'hD, d); check(d === 8'h00, "R1 status after reset", d, 0);
      rd(4'hE, d); check(d === 8'h00, "R1 control A after reset", d, 0);
      rd(4'hF, d); check(d === 8'h00, "R1 control B after reset", d, 0);
   endtask

   task automatic t_period(input int lat);
      logic [7:0] d;
      int t[3];
      wr(4'h4, lat[7:0]); wr(4'h5, lat[15:8]);
      wr(4'hD, 8'h81);
      wr(4'hE, 8'h01);
      for (int k = 0; k < 3; k++) begin
         int n0 = fall_n;
         wait_fall(n0);
         t[k] = last_fall;
         rd(4'hD, d);
      end
      for (int k = 1; k < 3; k++)
         check(t[k] - t[k-1] == lat + 1, "R2 free-running spacing", t[k] - t[k-1], lat + 1);
      flush();
      wr(4'hD, 8'h03);
   endtask

   task automatic t_oneshot(input int lat);
      logic [7:0] d;
      int ts, n0;
      wr(4'h4, lat[7:0]); wr(4'h5, lat[15:8]);
      wr(4'hD, 8'h81);
      n0 = fall_n;
      wr(4'hE, 8'h09);
      ts = cyc;
      wait_fall(n0);
      check(last_fall - ts == lat + 1, "R3 single-shot delay", last_fall - ts, lat + 1);
      repeat (lat + 20) @(negedge clk);
      check(irq_n === 1'b0, "R8 irq held until read", irq_n, 0);
      check(fall_n == n0 + 1, "R8 single falling edge", fall_n - n0, 1);
      rd(4'hE, d); check(d === 8'h08, "R3 start bit cleared", d, 8'h08);
      rd(4'hD, d); check(d === 8'h81, "R7 status after event", d, 8'h81);
      #1 check(irq_n === 1'b1, "R7 read releases irq", irq_n, 1);
      repeat (2*lat + 10) @(negedge clk);
      rd(4'hD, d); check(d === 8'h00, "R3 no further event", d, 0);
      wr(4'hD, 8'h03);
   endtask

   task automatic t_mask();
      logic [7:0] d;
      wr(4'hD, 8'h81);
      wr(4'hD, 8'h01);
      wr(4'hD, 8'h82);
      wr(4'h6, 8'h02); wr(4'h7, 8'h00);
      wr(4'hF, 8'h09);
      repeat (8) @(negedge clk);
      check(irq_n === 1'b0, "R6 enabled B drives irq", irq_n, 0);
      rd(4'hD, d); check(d === 8'h82, "R7 status for B", d, 8'h82);
      wr(4'h4, 8'h02); wr(4'h5, 8'h00);
      wr(4'hE, 8'h09);
      repeat (8) @(negedge clk);
      check(irq_n === 1'b1, "R6 cleared A mask keeps irq high", irq_n, 1);
      rd(4'hD, d); check(d === 8'h01, "R7 flag without enable", d, 8'h01);
      wr(4'hD, 8'h03);
   endtask

   task automatic t_load();
      logic [7:0] d;
      wr(4'hD, 8'h03);
      wr(4'h4, 8'h34); wr(4'h5, 8'h12);
      rd(4'h4, d); check(d === 8'h34, "R4 stopped load low", d, 8'h34);
      rd(4'h5, d); check(d === 8'h12, "R4 stopped load high", d, 8'h12);
      wr(4'hE, 8'h01);
      wr(4'h4, 8'h50); wr(4'h5, 8'h00);
      @(negedge clk); cnt_en = 1'b0;
      rd(4'h5, d); check(d === 8'h12, "R4 running high write no load", d, 8'h12);
      wr(4'hE, 8'h11);
      rd(4'h4, d); check(d === 8'h50, "R5 force-load low", d, 8'h50);
      rd(4'h5, d); check(d === 8'h00, "R5 force-load high", d, 8'h00);
      rd(4'hE, d); check(d === 8'h01, "R5 force bit reads 0", d, 8'h01);
      repeat (10) @(negedge clk);
      rd(4'h4, d); check(d === 8'h50, "R10 frozen while disabled", d, 8'h50);
      cnt_en = 1'b1;
      flush();
   endtask

   task automatic t_collide();
      logic [7:0] d;
      wr(4'h4, 8'h00); wr(4'h5, 8'h00);
      wr(4'hD, 8'h81);
      wr(4'hE, 8'h01);
      repeat (3) @(negedge clk);
      rd(4'hD, d); check(d === 8'h81, "R9 status during collision", d, 8'h81);
      check(irq_n === 1'b0, "R9 event kept over read", irq_n, 0);
      wr(4'hE, 8'h00);
      rd(4'hD, d); rd(4'hD, d);
      check(d === 8'h00, "R7 status clear after stop", d, 0);
      check(irq_n === 1'b1, "R7 irq released after stop", irq_n, 1);
      wr(4'hD, 8'h03);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_period(3);
      t_period(17);
      t_period(260);
      t_oneshot(0);
      t_oneshot(5);
      t_mask();
      t_load();
      t_collide();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule